// File: doc/BRIEF.md
# Feedforward-Patched Biquad PID Compensator

This block is the arithmetic core of a digital power-supply control loop. It takes one signed error sample per strobe and runs a second-order direct-form-I IIR filter that acts as a PID compensator. Its output is a duty command clamped to the duty range. The numerator taps b0, b1 and b2 are programmable and place the two zeros that form the proportional and derivative action. The recursive tap normally sits at a1 = -1, which makes the filter an integrator. The second recursive tap is held at zero.

When the sample arrives flagged as an input-voltage transient and carries a non-zero voltage step dV, the integrator coefficient is replaced for that one update by -(1 + dV*G). This rescales the remembered duty command in proportion to the supply change, so the feedforward correction is built into the integrator state and needs no separate multiply stage after the filter. G is a programmable gain near the reciprocal of the input voltage.

Two complete coefficient banks (b0, b1, b2, G) are held. A select input chooses the bank in use, so the bank that is not in use can be rewritten while the loop runs.

Top module: `bq_ff_pid`

## Requirements
- R1: While reset is asserted and after it is released, ctrlOut is 0, outValid is 0 and all filter history is zero.
- R2: Without sampleStb, ctrlOut and the filter history keep their values.
- R3: On each sampleStb the filter computes acc = b0*x[n] + b1*x[n-1] + b2*x[n-2] + A*y[n-1]. Here A = 2^FRAC, which is a1 = -1. Coefficients are signed with FRAC = 12 fractional bits.
- R4: The result is round(acc / 2^FRAC), computed as floor((acc + 2^(FRAC-1)) / 2^FRAC), then clamped to 0..2^DUTY_W-1. The y[n-1] history stores the clamped value, so the integrator cannot wind up.
- R5: When sampleStb arrives with transIn high and dvIn non-zero, that update uses A = 2^FRAC + dvIn*G.
- R6: When transIn is high with dvIn equal to zero, the update is identical to a normal one.
- R7: A patched integrator coefficient affects only its own update. The next strobe without transIn uses A = 2^FRAC again.
- R8: cfgWrEn writes cfgData into the bank cfgSet at cfgAddr, with 0 = b0, 1 = b1, 2 = b2 and 3 = G. setSel chooses the bank used by updates. Writing the bank that is not selected leaves the output unchanged.
- R9: ctrlOut carries the new value from the clock edge that samples sampleStb. outValid is high for exactly the following cycle and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low synchronous reset |
| sampleStb | input | 1 | one new error sample this cycle |
| errIn | input | ERR_W (12) | signed error sample |
| transIn | input | 1 | sample is flagged as an input-voltage transient |
| dvIn | input | DV_W (8) | signed input-voltage step for the transient |
| cfgWrEn | input | 1 | coefficient write strobe |
| cfgSet | input | 1 | bank written |
| cfgAddr | input | 2 | coefficient index: 0 b0, 1 b1, 2 b2, 3 G |
| cfgData | input | COEF_W (16) | signed coefficient value |
| setSel | input | 1 | bank used by updates |
| ctrlOut | output | DUTY_W (12) | clamped duty command |
| outValid | output | 1 | pulse after each update |

## Verification
The bench sweeps errors of both signs through a PID-shaped bank. This checks the three numerator taps and the unit integrator against an arithmetic model, including rounding at half-LSB boundaries. Long runs at full-scale error push the output into both clamps. The error is then reversed, and the reversal shows whether history held the clamped value or the raw one. Transient samples swept over positive and negative dV values are interleaved with plain samples. This separates a patched update from the reverted one that follows it, and zero dV from a real step. Switching banks, and writing the bank not in use while a loop is running, shows that coefficients are selected per update.

// File: rtl/bq_pkg.sv
package bq_pkg;
  // strobes from control to datapath, one sample update each
  typedef struct packed {
    logic update;  // run one filter step
    logic patch;   // replace integrator coefficient for this step
  } bqStrb_t;

  localparam int N_SETS  = 2;
  localparam int N_COEFS = 4;
  localparam int ADDR_W  = $clog2(N_COEFS);
  localparam int SET_W   = $clog2(N_SETS);
endpackage

// File: rtl/bq_ctrl.sv
module bq_ctrl
  import bq_pkg::*;
#(
  parameter int COEF_W = 16,
  parameter int DV_W   = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sampleStb,
  input  logic                     transIn,
  input  logic signed [DV_W-1:0]   dvIn,
  input  logic                     cfgWrEn,
  input  logic [SET_W-1:0]         cfgSet,
  input  logic [ADDR_W-1:0]        cfgAddr,
  input  logic signed [COEF_W-1:0] cfgData,
  input  logic [SET_W-1:0]         setSel,
  output bqStrb_t                  strb,
  output logic signed [COEF_W-1:0] b0Act,
  output logic signed [COEF_W-1:0] b1Act,
  output logic signed [COEF_W-1:0] b2Act,
  output logic signed [COEF_W-1:0] gAct
);
  logic signed [COEF_W-1:0] bank [N_SETS][N_COEFS];

  for (genvar s = 0; s < N_SETS; s++) begin : g_set
    for (genvar c = 0; c < N_COEFS; c++) begin : g_coef
      always_ff @(posedge clk) begin
        if (!rstN)
          bank[s][c] <= '0;
        else if (cfgWrEn && cfgSet == SET_W'(s) && cfgAddr == ADDR_W'(c))
          bank[s][c] <= cfgData;
      end
    end
  end

  assign b0Act = bank[setSel][0];
  assign b1Act = bank[setSel][1];
  assign b2Act = bank[setSel][2];
  assign gAct  = bank[setSel][3];

  always_comb begin
    strb.update = sampleStb;
    strb.patch  = sampleStb && transIn && (dvIn != '0);
  end

  // R8
  idle_bank_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgSet != setSel) |=> (setSel != $past(setSel)) ||
      ($stable(b0Act) && $stable(b1Act) && $stable(b2Act) && $stable(gAct)));
endmodule

// File: rtl/bq_datapath.sv
module bq_datapath
  import bq_pkg::*;
#(
  parameter int ERR_W  = 12,
  parameter int COEF_W = 16,
  parameter int DV_W   = 8,
  parameter int DUTY_W = 12,
  parameter int FRAC   = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  bqStrb_t                  strb,
  input  logic signed [ERR_W-1:0]  errIn,
  input  logic signed [DV_W-1:0]   dvIn,
  input  logic signed [COEF_W-1:0] b0Act,
  input  logic signed [COEF_W-1:0] b1Act,
  input  logic signed [COEF_W-1:0] b2Act,
  input  logic signed [COEF_W-1:0] gAct,
  output logic [DUTY_W-1:0]        ctrlOut,
  output logic                     outValid
);
  localparam int ACC_W = COEF_W + DV_W + DUTY_W + ERR_W;
  localparam logic signed [ACC_W-1:0] ONE  = ACC_W'(1) <<< FRAC;
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (FRAC - 1);
  localparam logic signed [ACC_W-1:0] DMAX = (ACC_W'(1) <<< DUTY_W) - ACC_W'(1);

  logic signed [ERR_W-1:0] xD1, xD2;
  logic [DUTY_W-1:0]       yD1;
  logic signed [ACC_W-1:0] a1Neg, acc, rnd;
  logic [DUTY_W-1:0]       ySat;

  always_comb begin
    a1Neg = ONE;
    if (strb.patch)
      a1Neg = ONE + ACC_W'(dvIn) * ACC_W'(gAct);
    acc = ACC_W'(b0Act) * ACC_W'(errIn)
        + ACC_W'(b1Act) * ACC_W'(xD1)
        + ACC_W'(b2Act) * ACC_W'(xD2)
        + a1Neg * ACC_W'({1'b0, yD1});
    rnd = (acc + HALF) >>> FRAC;
    if (rnd < 0)
      ySat = '0;
    else if (rnd > DMAX)
      ySat = DMAX[DUTY_W-1:0];
    else
      ySat = rnd[DUTY_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xD1      <= '0;
      xD2      <= '0;
      yD1      <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= strb.update;
      if (strb.update) begin
        xD1 <= errIn;
        xD2 <= xD1;
        yD1 <= ySat;
      end
    end
  end

  assign ctrlOut = yD1;

  // R9
  valid_after_stb_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.update |=> outValid);
  // R9
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.update |=> !outValid);
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.update |=> $stable(ctrlOut) && $stable(xD1) && $stable(xD2));
  // R4
  sat_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.update && rnd > DMAX) |=> ctrlOut == DMAX[DUTY_W-1:0]);
  // R4
  sat_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.update && rnd < 0) |=> ctrlOut == '0);
endmodule

// File: rtl/bq_ff_pid.sv
module bq_ff_pid
  import bq_pkg::*;
#(
  parameter int ERR_W  = 12,
  parameter int COEF_W = 16,
  parameter int DV_W   = 8,
  parameter int DUTY_W = 12,
  parameter int FRAC   = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sampleStb,
  input  logic signed [ERR_W-1:0]  errIn,
  input  logic                     transIn,
  input  logic signed [DV_W-1:0]   dvIn,
  input  logic                     cfgWrEn,
  input  logic                     cfgSet,
  input  logic [1:0]               cfgAddr,
  input  logic signed [COEF_W-1:0] cfgData,
  input  logic                     setSel,
  output logic [DUTY_W-1:0]        ctrlOut,
  output logic                     outValid
);
  bqStrb_t strb;
  logic signed [COEF_W-1:0] b0Act, b1Act, b2Act, gAct;

  bq_ctrl #(.COEF_W(COEF_W), .DV_W(DV_W)) uCtrl (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .transIn(transIn),
    .dvIn(dvIn), .cfgWrEn(cfgWrEn), .cfgSet(cfgSet), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .setSel(setSel), .strb(strb),
    .b0Act(b0Act), .b1Act(b1Act), .b2Act(b2Act), .gAct(gAct)
  );

  bq_datapath #(.ERR_W(ERR_W), .COEF_W(COEF_W), .DV_W(DV_W),
                .DUTY_W(DUTY_W), .FRAC(FRAC)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .errIn(errIn), .dvIn(dvIn),
    .b0Act(b0Act), .b1Act(b1Act), .b2Act(b2Act), .gAct(gAct),
    .ctrlOut(ctrlOut), .outValid(outValid)
  );
endmodule

// File: tb/bq_ff_pid_test.sv
module bq_ff_pid_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleStb = 1'b0, transIn = 1'b0, cfgWrEn = 1'b0, cfgSet = 1'b0, setSel = 1'b0;
  logic signed [11:0] errIn = '0;
  logic signed [7:0]  dvIn = '0;
  logic [1:0]         cfgAddr = '0;
  logic signed [15:0] cfgData = '0;
  logic [11:0]        ctrlOut;
  logic               outValid;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  longint mc [2][4];
  longint mx1 = 0, mx2 = 0, my1 = 0;
  int selM = 0;

  bq_ff_pid uut (.*);

  always #2.5 clk = ~clk;

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic wrCoef(int s, int a, longint v);
    @(negedge clk);
    cfgWrEn = 1; cfgSet = s[0]; cfgAddr = a[1:0]; cfgData = 16'(v);
    @(negedge clk);
    cfgWrEn = 0;
    mc[s][a] = v;
  endtask

  function automatic longint model(longint x, bit tr, longint dv);
    longint a, acc, r;
    a = 4096;
    if (tr && dv != 0) a = 4096 + dv * mc[selM][3];
    acc = mc[selM][0] * x + mc[selM][1] * mx1 + mc[selM][2] * mx2 + a * my1;
    r = (acc + 2048) >>> 12;
    if (r < 0) r = 0;
    if (r > 4095) r = 4095;
    mx2 = mx1; mx1 = x; my1 = r;
    return r;
  endfunction

  task automatic step(longint x, bit tr, longint dv, string req);
    longint exp;
    @(negedge clk);
    errIn = 12'(x); transIn = tr; dvIn = 8'(dv); sampleStb = 1;
    @(negedge clk);
    sampleStb = 0; transIn = 0;
    exp = model(x, tr, dv);
    check(req, ctrlOut, exp);
    check("R9", outValid, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during and after reset
    check("R1", ctrlOut, 0);
    check("R1", outValid, 0);
    rstN = 1;
    @(negedge clk);
    check("R1", ctrlOut, 0);
    check("R1", outValid, 0);

    // bank 0: PID-like; bank 1: different shape
    wrCoef(0, 0, 6144); wrCoef(0, 1, -5000); wrCoef(0, 2, 1024); wrCoef(0, 3, 90);
    wrCoef(1, 0, 3000); wrCoef(1, 1, -2000); wrCoef(1, 2, 0);    wrCoef(1, 3, -250);

    // R3 sweep over error values of both signs, incl. rounding points
    for (int x = -40; x <= 120; x += 5) step(x, 0, 0, "R3");
    for (int x = 60; x >= -30; x -= 3) step(x, 0, 0, "R3");

    // R9 idle cycle after strobe, R2 hold
    @(negedge clk);
    check("R9", outValid, 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R2", ctrlOut, my1);
    end

    // R4 high clamp, then reversal shows stored clamped value
    for (int k = 0; k < 6; k++) step(2047, 0, 0, "R4");
    check("R4", ctrlOut, 4095);
    for (int k = 0; k < 6; k++) step(-2048, 0, 0, "R4");
    for (int k = 0; k < 4; k++) step(-2048, 0, 0, "R4");
    check("R4", ctrlOut, 0);
    for (int k = 0; k < 8; k++) step(400, 0, 0, "R4");

    // R5/R7/R6 transient patching over a dV sweep
    for (int dv = -128; dv <= 127; dv += 17) begin
      step(30, 1, dv, "R5");
      step(30, 0, 0, "R7");
      step(-10, 1, 0, "R6");
      step(25, 0, dv, "R7");
    end

    // R8 switch to bank 1 and run
    @(negedge clk); setSel = 1; selM = 1;
    for (int x = -20; x <= 100; x += 10) step(x, 0, 0, "R8");
    step(50, 1, 40, "R5");
    // R8 rewrite the idle bank mid-run; output must still follow bank 1
    wrCoef(0, 0, -7000); wrCoef(0, 3, 3000);
    for (int x = 0; x <= 60; x += 15) step(x, 0, 0, "R8");
    // R8 switch back to the rewritten bank 0
    @(negedge clk); setSel = 0; selM = 0;
    for (int x = -50; x <= 0; x += 10) step(x, 0, 0, "R8");
    step(-5, 1, -60, "R5");
    step(-5, 0, 0, "R7");

    finishRun();
  end
endmodule